// File: doc/BRIEF.md
# UART Transmit Channel with FIFO, Trigger Interrupt and Ready Request

This block is the transmit side of one serial channel. The host pushes bytes into a 64-entry FIFO one write strobe at a time. A serializer pulls the bytes out in order and sends each one as an 8-N-1 frame on a line that idles high. Bit timing comes from an external 16x baud tick. When the serializer finishes a frame and the FIFO still holds data, it starts the next frame without waiting for the host.

The block raises a transmit interrupt when the FIFO occupancy falls below a level the host chooses from four values. The host clears a pending interrupt in one of two ways: by reading the status register, or by writing enough bytes to bring the occupancy back up to that level. A separate active-low ready output paces the host or a DMA engine. With DMA mode off, it is active only while the FIFO is empty. With DMA mode on, it is active whenever at least one FIFO slot is free.

Top module: `uart_tx_chan`

## Requirements
- R1: `level_o` reports the number of bytes in the FIFO. The range is 0 to 64, and the value is 0 after reset.
- R2: A write strobe that arrives while `level_o` is 64 is dropped. The occupancy does not change.
- R3: `txd_o` is high when no frame is in progress. A frame is one low start bit, the eight data bits with bit 0 sent first, and one high stop bit.
- R4: Each bit lasts 16 pulses of `baud_tick_i`. When the serializer is idle and the FIFO is not empty, it takes the oldest byte on the next clock and drives the start bit from that clock on. When a frame ends and more data is waiting, the next frame starts one clock later.
- R5: `trig_sel_i` chooses the trigger level. The codes 0, 1, 2 and 3 select 8, 16, 32 and 56 bytes.
- R6: The interrupt becomes pending on the clock edge where the occupancy goes from at least the trigger level to below it.
- R7: A pulse on `isr_rd_i` clears the pending interrupt at the next edge. If a set event happens on the same edge, the set event takes priority.
- R8: The pending interrupt clears on the edge where host writes raise the occupancy from below the trigger level to at least the trigger level.
- R9: `irq_o` is the pending flag ANDed with `irq_en_i`, with no register in between. Dropping the enable removes the output at once, but the pending flag stays set.
- R10: When `dma_mode_i` is 0, `ready_no` is low exactly when the FIFO is empty.
- R11: When `dma_mode_i` is 1, `ready_no` is high exactly when the FIFO holds 64 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe, one byte per cycle |
| wr_data_i | input | 8 | Byte to queue |
| irq_en_i | input | 1 | Transmit interrupt enable |
| isr_rd_i | input | 1 | Status-register read pulse |
| trig_sel_i | input | 2 | Trigger level code |
| dma_mode_i | input | 1 | Selects the rule for the ready output |
| baud_tick_i | input | 1 | 16x baud pulse |
| txd_o | output | 1 | Serial line |
| irq_o | output | 1 | Transmit interrupt |
| ready_no | output | 1 | Transmit ready / DMA request, active low |
| level_o | output | 7 | FIFO occupancy |

## Verification
The hardest state to reach from the ports is a full FIFO with writes still arriving while a frame is in flight. The next hardest is an interrupt that is pending while its enable is off. The bench stops the baud tick so the FIFO cannot drain, fills it past 64 entries, and then switches DMA mode on. It then lets the FIFO drain slowly through the highest trigger level. It toggles the enable while the interrupt is pending, and refills the FIFO to clear the interrupt. A behavioural model built on a queue is compared with every output on every clock.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic {SER_IDLE, SER_BUSY} ser_state_e;

  function automatic int unsigned trig_level(input logic [1:0] code);
    case (code)
      2'd0:    return 8;
      2'd1:    return 16;
      2'd2:    return 32;
      default: return 56;
    endcase
  endfunction
endpackage

// File: rtl/tx_fifo.sv
module tx_fifo #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned W     = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  logic [W-1:0]                 din_i,
  input  logic                         pop_i,
  output logic [W-1:0]                 dout_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic                         full_o,
  output logic                         empty_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wptr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= nxt(wptr_q);
      if (pop_i)  rptr_q <= nxt(rptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout_o  = mem_q[rptr_q];
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/tx_serializer.sv
module tx_serializer
  import uart_tx_pkg::*;
#(
  parameter int unsigned W   = 8,
  parameter int unsigned OVS = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         tick_i,
  output logic         busy_o,
  output logic         txd_o
);
  localparam int unsigned FRAME_W = W + 2;
  localparam int unsigned BIT_W   = $clog2(FRAME_W);
  localparam int unsigned TICK_W  = $clog2(OVS);

  ser_state_e         state_q;
  logic [FRAME_W-1:0] frame_q;
  logic [BIT_W-1:0]   bit_q;
  logic [TICK_W-1:0]  tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SER_IDLE;
      frame_q <= '1;
      bit_q   <= '0;
      tick_q  <= '0;
    end else if (state_q == SER_IDLE) begin
      if (load_i) begin
        frame_q <= {1'b1, data_i, 1'b0};
        bit_q   <= '0;
        tick_q  <= '0;
        state_q <= SER_BUSY;
      end
    end else if (tick_i) begin
      if (tick_q == TICK_W'(OVS-1)) begin
        tick_q <= '0;
        if (bit_q == BIT_W'(FRAME_W-1)) state_q <= SER_IDLE;
        else                            bit_q   <= bit_q + 1'b1;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  assign busy_o = (state_q == SER_BUSY);
  assign txd_o  = busy_o ? frame_q[bit_q] : 1'b1;
endmodule

// File: rtl/tx_irq_ready.sv
module tx_irq_ready
  import uart_tx_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [$clog2(DEPTH+1)-1:0] count_i,
  input  logic                       push_i,
  input  logic                       pop_i,
  input  logic [1:0]                 trig_sel_i,
  input  logic                       isr_rd_i,
  input  logic                       irq_en_i,
  input  logic                       dma_mode_i,
  output logic                       irq_o,
  output logic                       ready_no
);
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  logic [CNT_W-1:0] thr, cnt_nxt;
  logic             fall_evt, rise_evt, pend_q;

  always_comb begin
    thr     = CNT_W'(trig_level(trig_sel_i));
    cnt_nxt = count_i + CNT_W'(push_i) - CNT_W'(pop_i);
  end

  assign fall_evt = (count_i >= thr) && (cnt_nxt < thr);
  assign rise_evt = (count_i < thr) && (cnt_nxt >= thr);

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     pend_q <= 1'b0;
    else if (fall_evt)               pend_q <= 1'b1;
    else if (rise_evt || isr_rd_i)   pend_q <= 1'b0;
  end

  assign irq_o    = pend_q & irq_en_i;
  assign ready_no = dma_mode_i ? (count_i == CNT_W'(DEPTH)) : (count_i != '0);
endmodule

// File: rtl/uart_tx_chan.sv
module uart_tx_chan #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned OVS   = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [7:0]                 wr_data_i,
  input  logic                       irq_en_i,
  input  logic                       isr_rd_i,
  input  logic [1:0]                 trig_sel_i,
  input  logic                       dma_mode_i,
  input  logic                       baud_tick_i,
  output logic                       txd_o,
  output logic                       irq_o,
  output logic                       ready_no,
  output logic [$clog2(DEPTH+1)-1:0] level_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  logic [7:0]       fifo_dout;
  logic [CNT_W-1:0] fifo_cnt;
  logic             fifo_full, fifo_empty, ser_busy;
  logic             push_ok, pop_ok;

  assign push_ok = wr_en_i && !fifo_full;
  assign pop_ok  = !ser_busy && !fifo_empty;

  tx_fifo #(.DEPTH(DEPTH), .W(8)) i_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_i(push_ok), .din_i(wr_data_i),
    .pop_i(pop_ok), .dout_o(fifo_dout),
    .count_o(fifo_cnt), .full_o(fifo_full), .empty_o(fifo_empty)
  );

  tx_serializer #(.W(8), .OVS(OVS)) i_ser (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(pop_ok), .data_i(fifo_dout), .tick_i(baud_tick_i),
    .busy_o(ser_busy), .txd_o(txd_o)
  );

  tx_irq_ready #(.DEPTH(DEPTH)) i_irq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .count_i(fifo_cnt), .push_i(push_ok), .pop_i(pop_ok),
    .trig_sel_i(trig_sel_i), .isr_rd_i(isr_rd_i),
    .irq_en_i(irq_en_i), .dma_mode_i(dma_mode_i),
    .irq_o(irq_o), .ready_no(ready_no)
  );

  assign level_o = fifo_cnt;
endmodule

// File: rtl/uart_tx_chan_chk.sv
module uart_tx_chan_chk #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CNT_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             irq_en_i,
  input logic             dma_mode_i,
  input logic [CNT_W-1:0] level_i,
  input logic             pop_i,
  input logic             busy_i,
  input logic             txd_i,
  input logic             irq_i,
  input logic             ready_ni
);
  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_i <= CNT_W'(DEPTH)); // R1
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i == CNT_W'(DEPTH)) && !pop_i |=> level_i == CNT_W'(DEPTH)); // R2
  AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> txd_i); // R3
  AST_START_AFTER_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |=> busy_i && !txd_i); // R4
  AST_IRQ_EN_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_en_i) |-> !irq_i); // R9
  AST_RDY_NODMA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_mode_i && wr_en_i && !pop_i |=> ready_ni || dma_mode_i); // R10
  AST_RDY_DMA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_mode_i && pop_i && !wr_en_i |=> !ready_ni || !dma_mode_i); // R11
endmodule

bind uart_tx_chan uart_tx_chan_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .irq_en_i(irq_en_i),
  .dma_mode_i(dma_mode_i), .level_i(level_o), .pop_i(pop_ok),
  .busy_i(ser_busy), .txd_i(txd_o), .irq_i(irq_o), .ready_ni(ready_no)
);

// File: tb/test_uart_tx_chan.sv
`timescale 1ns/1ps
module test_uart_tx_chan;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, irq_en = 0, isr_rd = 0, dma = 0, tick = 0;
  logic [7:0] wd = 0;
  logic [1:0] trig = 0;
  logic txd, irq, rdy_n;
  logic [6:0] level;
  int checks = 0, errors = 0, cyc = 0, tick_mode = 0, tick_div = 0;

  always #2 clk = ~clk;

  uart_tx_chan i_uart_tx_chan (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wd),
    .irq_en_i(irq_en), .isr_rd_i(isr_rd), .trig_sel_i(trig),
    .dma_mode_i(dma), .baud_tick_i(tick),
    .txd_o(txd), .irq_o(irq), .ready_no(rdy_n), .level_o(level)
  );

  // reference model
  logic [7:0] q[$];
  logic [7:0] fr;
  bit busy = 0, pend = 0;
  int fr_tick = 0;

  function automatic int thr(input logic [1:0] c);
    int t[4] = '{8, 16, 32, 56};
    return t[c];
  endfunction

  function automatic bit exp_txd();
    int b;
    if (!busy) return 1'b1;
    b = fr_tick / 16;
    if (b == 0) return 1'b0;
    if (b == 9) return 1'b1;
    return fr[b-1];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); busy = 0; pend = 0; fr_tick = 0;
    end else begin
      int o, n, t;
      o = q.size();
      if (!busy) begin
        if (q.size() > 0) begin fr = q.pop_front(); busy = 1; fr_tick = 0; end
      end else if (tick) begin
        if (fr_tick == 159) busy = 0; else fr_tick++;
      end
      if (wr_en && o < 64) q.push_back(wd);
      n = q.size(); t = thr(trig);
      if (o >= t && n < t) pend = 1;
      else if ((o < t && n >= t) || isr_rd) pend = 0;
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison just after each edge
  always @(posedge clk) begin
    cyc++;
    #1;
    if (rst_n) begin
      chk(level, q.size(), "R1 R2 level");
      chk(txd, exp_txd(), "R3 R4 txd");
      chk(irq, pend && irq_en, "R6 R7 R8 R9 irq");
      if (dma) chk(rdy_n, q.size() == 64, "R11 ready");
      else     chk(rdy_n, q.size() != 0, "R10 ready");
    end
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <190000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    tick_div = (tick_div + 1) % 3;
    tick <= (tick_mode == 1) || (tick_mode == 3 && tick_div == 0);
  end

  task automatic put(input logic [7:0] b);
    wr_en = 1; wd = b; @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_irq(input int limit);
    for (int i = 0; i < limit && !irq; i++) @(negedge clk);
  endtask

  initial begin
    int w;
    repeat (3) @(negedge clk);
    // reset state
    chk(level, 0, "R1 reset level");
    chk(rdy_n, 0, "R10 reset ready");
    chk(irq, 0, "R9 reset irq");
    chk(txd, 1, "R3 reset idle");
    rst_n = 1;
    @(negedge clk);

    // phase A: trigger 8, continuous ticks
    irq_en = 1; trig = 2'd0; tick_mode = 1;
    for (int i = 0; i < 10; i++) put(8'h30 + 8'(i * 37));
    wait_irq(5000);
    chk(level, 7, "R5 R6 irq at level below 8");
    isr_rd = 1; @(negedge clk); isr_rd = 0;
    chk(irq, 0, "R7 cleared by status read");
    for (int i = 0; i < 3000 && (level != 0 || txd == 0); i++) @(negedge clk);
    repeat (200) @(negedge clk);

    // start bit width with all-ones byte
    put(8'hFF);
    for (int i = 0; i < 10 && txd; i++) @(negedge clk);
    w = 0;
    for (int i = 0; i < 40 && !txd; i++) begin w++; @(negedge clk); end
    chk(w, 16, "R4 start bit length in ticks");
    repeat (200) @(negedge clk);

    // phase B: fill without draining, highest trigger
    tick_mode = 0; trig = 2'd3;
    for (int i = 0; i < 70; i++) put(8'(i * 7 + 1));
    chk(level, 64, "R2 writes to full dropped");
    dma = 1; @(negedge clk);
    chk(rdy_n, 1, "R11 full in dma mode");
    tick_mode = 3;
    wait_irq(40000);
    chk(level, 55, "R5 R6 irq below 56");
    tick_mode = 0;
    irq_en = 0; #0.1;
    chk(irq, 0, "R9 enable drop");
    @(negedge clk); irq_en = 1; #0.1;
    chk(irq, 1, "R9 pending kept");
    @(negedge clk);
    for (int i = 0; i < 3; i++) put(8'hA5 ^ 8'(i));
    chk(irq, 0, "R8 refill to trigger clears");

    // phase C: drain through lower triggers, no dma
    dma = 0; trig = 2'd1; tick_mode = 3;
    wait_irq(40000);
    chk(level, 15, "R5 R6 irq below 16");
    trig = 2'd2;
    for (int i = 0; i < 2; i++) put(8'h5A + 8'(i));
    for (int i = 0; i < 40000 && level != 0; i++) @(negedge clk);
    repeat (600) @(negedge clk);
    chk(rdy_n, 0, "R10 empty after drain");
    chk(txd, 1, "R3 idle after drain");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule